// File: doc/BRIEF.md
# Caller-ID Serial Byte Interface

This block sits between an FSK demodulator and a microcontroller. It accepts the demodulated 1200 baud bit stream, which is asynchronous and framed as a low start bit, eight data bits sent least significant bit first, and a high stop bit. It offers that stream to the host in one of two ways, chosen by a mode input. In the streaming mode the raw bit stream appears on the serial output pin. In the clocked mode the block frames each character, holds the byte in a shift register, raises an active-low ready flag, and hands the bits out one per rising edge of a host-supplied read clock.

A carrier-detect input gates both modes. While no carrier is reported, the streaming output idles high and the clocked path neither takes new bytes nor raises the ready flag. Bit timing comes from a fractional phase accumulator, so any system clock can be used. The accumulator restarts on each start-bit falling edge and samples every bit near its centre.

Top module: `cid_serial_if`

## Requirements
- R1: While reset is held and in the first cycle after it, `ser_data` is 1 and `data_rdy_n` is 1.
- R2: With `mode_sel`=0 and `carrier_det`=1, `ser_data` equals `demod_bit` in the same cycle.
- R3: With `mode_sel`=0 and `carrier_det`=0, `ser_data` is 1 whatever `demod_bit` does.
- R4: With `mode_sel`=1 and carrier present, a character whose stop bit samples as 1 drives `data_rdy_n` low within two clocks after the centre of the stop bit.
- R5: In mode 1, the k-th rising edge of `rd_clk` after a byte is loaded (k = 1..8) places data bit k-1 of that byte on `ser_data`. Bit 0 is the first bit received after the start bit. The pin changes within four system clocks of the edge.
- R6: A rising edge of `rd_clk` while `data_rdy_n` is low returns `data_rdy_n` to 1 before the auto-clear would.
- R7: With no read clock, `data_rdy_n` returns to 1 half a bit period after the stop-bit sample. It never stays low longer than one bit period plus four clocks.
- R8: After eight read edges, further `rd_clk` edges are ignored and `ser_data` keeps the byte's bit 7.
- R9: A character whose stop bit samples as 0 is discarded. `data_rdy_n` stays 1, and the shift register keeps its old contents, so a read edge leaves `ser_data` unchanged.
- R10: In mode 1 with `carrier_det`=0, a complete character raises no ready flag and loads nothing.
- R11: A low pulse on `demod_bit` that ends before the start-bit centre does not start a character.
- R12: In mode 0, `data_rdy_n` stays 1 even while complete characters arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 = stream raw bits, 1 = host-clocked bytes |
| carrier_det | input | 1 | Carrier present, active high |
| demod_bit | input | 1 | Demodulated bit stream, synchronous to clk |
| rd_clk | input | 1 | Host read clock, asynchronous |
| ser_data | output | 1 | Serial data to the host |
| data_rdy_n | output | 1 | Byte ready, active low |

## Verification
The bit-timing accumulator or the framer state can be wrong without anything showing inside a cycle. What the host sees is a byte whose bits have moved by one place, or a ready flag that never falls. Either shows up at the first read of the next character, so every random byte is read back in full and compared. A stuck count of remaining bits shows as the wrong value on `ser_data` after the eighth read edge. A ready flag that does not clear shows within one bit period, when the pin is sampled just after the expected clear point.

// File: rtl/cid_pkg.sv
package cid_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    function automatic logic is_fall(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction
endpackage

// File: rtl/cid_bit_timer.sv
module cid_bit_timer #(
    parameter int unsigned CLK_HZ = 3579545,
    parameter int unsigned BAUD   = 1200
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic half_tick,
    output logic sample_tick
);
    localparam int unsigned INC   = 2 * BAUD;
    localparam int unsigned ACC_W = $clog2(CLK_HZ + INC + 1);
    localparam logic [ACC_W-1:0] INC_V = INC[ACC_W-1:0];
    localparam logic [ACC_W-1:0] MOD_V = CLK_HZ[ACC_W-1:0];

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;
    logic             phase;
    logic             wrap;

    assign sum         = acc + INC_V;
    assign wrap        = (sum >= MOD_V);
    assign half_tick   = wrap & ~restart;
    assign sample_tick = half_tick & ~phase;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            acc   <= sum - MOD_V;
            phase <= ~phase;
        end else begin
            acc   <= sum;
        end
    end
endmodule

// File: rtl/cid_framer.sv
module cid_framer
    import cid_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     bit_in,
    input  logic     sample_tick,
    output logic     restart,
    output rx_byte_t byte_o
);
    rx_state_e         st;
    logic              prev_bit;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;

    assign restart = (st == RX_IDLE) && enable && is_fall(prev_bit, bit_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RX_IDLE;
            prev_bit <= 1'b1;
            cnt      <= '0;
            shreg    <= '0;
            byte_o   <= '0;
        end else begin
            prev_bit     <= bit_in;
            byte_o.valid <= 1'b0;
            if (!enable) begin
                st <= RX_IDLE;
            end else begin
                case (st)
                    RX_IDLE: if (restart) st <= RX_START;
                    RX_START: if (sample_tick) begin
                        st  <= bit_in ? RX_IDLE : RX_DATA;
                        cnt <= '0;
                    end
                    RX_DATA: if (sample_tick) begin
                        shreg <= {bit_in, shreg[BYTE_W-1:1]};
                        cnt   <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W - 1)) st <= RX_STOP;
                    end
                    RX_STOP: if (sample_tick) begin
                        st <= RX_IDLE;
                        if (bit_in) begin
                            byte_o.valid <= 1'b1;
                            byte_o.data  <= shreg;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cid_read_port.sv
module cid_read_port
    import cid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clocked_mode,
    input  logic              rd_clk,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              half_tick,
    output logic              dr_n,
    output logic              out_bit,
    output logic              dclk_rise
);
    logic [2:0]        sync;
    logic [BYTE_W-1:0] sreg;
    logic [CNT_W:0]    left;

    assign dclk_rise = sync[1] & ~sync[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync    <= '0;
            sreg    <= '0;
            left    <= '0;
            dr_n    <= 1'b1;
            out_bit <= 1'b1;
        end else begin
            sync <= {sync[1:0], rd_clk};
            if (!clocked_mode) begin
                dr_n <= 1'b1;
            end else if (load) begin
                sreg <= load_data;
                left <= (CNT_W+1)'(BYTE_W);
                dr_n <= 1'b0;
            end else begin
                if (dclk_rise && left != '0) begin
                    out_bit <= sreg[0];
                    sreg    <= sreg >> 1;
                    left    <= left - 1'b1;
                end
                if (dclk_rise || half_tick) dr_n <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cid_serial_if.sv
module cid_serial_if
    import cid_pkg::*;
#(
    parameter int unsigned CLK_HZ = 3579545,
    parameter int unsigned BAUD   = 1200
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_sel,
    input  logic carrier_det,
    input  logic demod_bit,
    input  logic rd_clk,
    output logic ser_data,
    output logic data_rdy_n
);
    logic     restart;
    logic     half_tick;
    logic     sample_tick;
    logic     out_bit;
    logic     dclk_rise;
    rx_byte_t rx_byte;

    cid_bit_timer #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_timer (
        .clk(clk), .rst(rst), .restart(restart),
        .half_tick(half_tick), .sample_tick(sample_tick)
    );

    cid_framer u_framer (
        .clk(clk), .rst(rst), .enable(carrier_det), .bit_in(demod_bit),
        .sample_tick(sample_tick), .restart(restart), .byte_o(rx_byte)
    );

    cid_read_port u_port (
        .clk(clk), .rst(rst), .clocked_mode(mode_sel), .rd_clk(rd_clk),
        .load(rx_byte.valid), .load_data(rx_byte.data), .half_tick(half_tick),
        .dr_n(data_rdy_n), .out_bit(out_bit), .dclk_rise(dclk_rise)
    );

    always_comb begin
        if (mode_sel)         ser_data = out_bit;
        else if (carrier_det) ser_data = demod_bit;
        else                  ser_data = 1'b1;
    end
endmodule

// File: rtl/cid_serial_if_chk.sv
module cid_serial_if_chk #(
    parameter int unsigned CLK_HZ = 3579545,
    parameter int unsigned BAUD   = 1200
) (
    input logic clk,
    input logic rst,
    input logic mode_sel,
    input logic carrier_det,
    input logic demod_bit,
    input logic ser_data,
    input logic data_rdy_n,
    input logic frame_done,
    input logic dclk_rise
);
    localparam int unsigned LOW_LIMIT = 2 * (CLK_HZ / (2 * BAUD) + 1) + 4;

    logic [31:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst || data_rdy_n) low_cnt <= '0;
        else                   low_cnt <= low_cnt + 1'b1;
    end

    // R12: streaming mode keeps the ready flag idle
    assert_mode0_dr_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !mode_sel |=> data_rdy_n);

    // R3: streaming mode without carrier holds the line high
    assert_mode0_nocarrier_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && !carrier_det) |-> ser_data);

    // R10: a ready flag only falls after a cycle with carrier present
    assert_dr_needs_carrier_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(data_rdy_n) |-> $past(carrier_det));

    // R9: an accepted character had a high stop-bit sample
    assert_stop_high_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(demod_bit));

    // R6: a read edge clears a pending ready flag
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (dclk_rise && !data_rdy_n && !frame_done && mode_sel) |=> data_rdy_n);

    // R7: the ready flag has a bounded low time
    assert_dr_width_R7: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LOW_LIMIT);
endmodule

bind cid_serial_if cid_serial_if_chk #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .carrier_det(carrier_det),
    .demod_bit(demod_bit), .ser_data(ser_data), .data_rdy_n(data_rdy_n),
    .frame_done(rx_byte.valid), .dclk_rise(dclk_rise)
);

// File: tb/cid_serial_if_bench.sv
module cid_serial_if_bench;
    localparam int unsigned CLK_HZ = 120000;
    localparam int unsigned BAUD   = 1200;
    localparam int BITC = CLK_HZ / BAUD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0, carrier_det = 1'b0, demod_bit = 1'b1, rd_clk = 1'b0;
    logic ser_data, data_rdy_n;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cid_serial_if #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_cid_serial_if (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .carrier_det(carrier_det),
        .demod_bit(demod_bit), .rd_clk(rd_clk),
        .ser_data(ser_data), .data_rdy_n(data_rdy_n)
    );

    function automatic logic exp_stream(input logic cd, input logic b);
        return cd ? b : 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // start + 8 data bits, then stop bit for 80% of a bit; returns near stop-bit end
    task automatic send_char(input logic [7:0] b, input logic stop_v);
        demod_bit = 1'b0; wait_cyc(BITC);
        for (int i = 0; i < 8; i++) begin demod_bit = b[i]; wait_cyc(BITC); end
        demod_bit = stop_v; wait_cyc(BITC * 8 / 10);
        demod_bit = 1'b1;
    endtask

    task automatic pulse_rd();
        rd_clk = 1'b1; wait_cyc(8);
        rd_clk = 1'b0; wait_cyc(8);
    endtask

    task automatic read_char(input logic [7:0] exp, input bit chk_dr);
        logic [7:0] got;
        for (int i = 0; i < 8; i++) begin
            rd_clk = 1'b1; wait_cyc(8);
            got[i] = ser_data;
            if (i == 0 && chk_dr) check(data_rdy_n == 1'b1, "R6", data_rdy_n, 1);
            rd_clk = 1'b0; wait_cyc(8);
        end
        check(got == exp, "R5", got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [7:0] last;
        void'($urandom(32'd1357));
        wait_cyc(3);
        check(ser_data == 1'b1 && data_rdy_n == 1'b1, "R1", {ser_data, data_rdy_n}, 3);
        rst = 1'b0;
        wait_cyc(1);
        check(ser_data == 1'b1 && data_rdy_n == 1'b1, "R1", {ser_data, data_rdy_n}, 3);

        // streaming mode, carrier on then off
        for (int pass = 0; pass < 2; pass++) begin
            carrier_det = (pass == 0);
            for (int i = 0; i < 20; i++) begin
                demod_bit = 1'($urandom);
                #1;
                check(ser_data == exp_stream(carrier_det, demod_bit),
                      carrier_det ? "R2" : "R3", ser_data, exp_stream(carrier_det, demod_bit));
                wait_cyc(1);
            end
        end
        demod_bit = 1'b1;
        carrier_det = 1'b1;
        wait_cyc(BITC);

        // R12: full character in streaming mode raises no flag
        fork
            send_char(8'hA5, 1'b1);
            begin
                bit low_seen = 0;
                for (int i = 0; i < BITC * 10; i++) begin
                    if (!data_rdy_n) low_seen = 1;
                    wait_cyc(1);
                end
                check(!low_seen, "R12", low_seen, 0);
            end
        join
        wait_cyc(BITC);

        // clocked mode: random characters read back
        mode_sel = 1'b1;
        wait_cyc(BITC);
        for (int n = 0; n < 6; n++) begin
            b = 8'($urandom);
            b[7] = 1'b1;
            send_char(b, 1'b1);
            check(data_rdy_n == 1'b0, "R4", data_rdy_n, 0);
            read_char(b, 1'b1);
            pulse_rd(); pulse_rd();
            check(ser_data == b[7], "R8", ser_data, b[7]);
            wait_cyc(BITC);
            last = b;
        end

        // R7: no read clock, auto-clear after half a bit
        send_char(8'h3C, 1'b1);
        check(data_rdy_n == 1'b0, "R4", data_rdy_n, 0);
        wait_cyc(BITC * 4 / 10);
        check(data_rdy_n == 1'b1, "R7", data_rdy_n, 1);
        read_char(8'h3C, 1'b0);
        last = 8'h3C;
        wait_cyc(BITC);

        // R9: bad stop bit discarded
        send_char(8'hF1, 1'b0);
        check(data_rdy_n == 1'b1, "R9", data_rdy_n, 1);
        pulse_rd();
        check(ser_data == last[7], "R9", ser_data, last[7]);
        wait_cyc(BITC * 2);

        // R10: no carrier in clocked mode
        carrier_det = 1'b0;
        send_char(8'h81, 1'b1);
        check(data_rdy_n == 1'b1, "R10", data_rdy_n, 1);
        pulse_rd();
        check(ser_data == last[7], "R10", ser_data, last[7]);
        carrier_det = 1'b1;
        wait_cyc(BITC * 2);

        // R11: short low glitch does not start a character
        demod_bit = 1'b0; wait_cyc(BITC / 10);
        demod_bit = 1'b1;
        begin
            bit low_seen = 0;
            for (int i = 0; i < BITC * 11; i++) begin
                if (!data_rdy_n) low_seen = 1;
                wait_cyc(1);
            end
            check(!low_seen, "R11", low_seen, 0);
        end

        // a good character still works afterwards
        send_char(8'h96, 1'b1);
        check(data_rdy_n == 1'b0, "R4", data_rdy_n, 0);
        read_char(8'h96, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule